// File: doc/BRIEF.md
# Branch Target Calculator with Scaled Short Offsets

This unit works out where the program counter goes after a conditional branch. Each cycle that `in_valid` is high, it takes the address of the branch (`br_pc`), the address of the next sequential instruction (`seq_pc`), a raw displacement field, a two-bit width code and the outcome of the branch condition. From these it registers the next program counter and a flag that reports a misaligned target.

The displacement is signed and comes in three widths. The 8-bit form is counted in halfwords, so it is doubled before the add. The 16-bit and 32-bit forms are byte counts. They are added unchanged, but they must be even, because instructions sit on halfword boundaries. When a taken branch carries an odd long displacement, the unit raises the error flag and keeps the program counter where it was. When the branch is not taken, the sequential address is passed through. Instruction fetch and the evaluation of condition codes are done by neighbouring logic.

Top module: `bt_target_calc`

## Requirements
- R1: While `rst_n` is low, and after it rises, `next_pc` reads 0x00000000 and `align_err` reads 0 until the first valid input is taken.
- R2: With width code 2'b00 and a taken branch, bits [7:0] of `disp_raw` are sign-extended, multiplied by two and added to `br_pc`, and `align_err` is 0.
- R3: With width code 2'b01 and a taken branch with an even displacement, bits [15:0] of `disp_raw` are sign-extended and added to `br_pc` without scaling.
- R4: With width code 2'b10 or 2'b11 and a taken branch with an even displacement, all 32 bits of `disp_raw` are added to `br_pc` without scaling.
- R5: The add wraps modulo 2^32 in both directions.
- R6: A taken branch with width code 2'b01, 2'b10 or 2'b11 whose displacement has bit 0 set drives `align_err` to 1 and leaves `next_pc` at its previous value.
- R7: A branch that is not taken loads `seq_pc` into `next_pc` and clears `align_err`, whatever the displacement and width code.
- R8: The short form never flags an error, even when the 8-bit field is odd.
- R9: Bits of `disp_raw` above the selected width have no effect on `next_pc` or `align_err`.
- R10: Both outputs change only on the rising clock edge after a cycle with `in_valid` high. In every other cycle they hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inputs are valid this cycle |
| br_pc | input | 32 | Address of the branch, the base for the target |
| seq_pc | input | 32 | Fall-through address |
| disp_raw | input | 32 | Raw displacement field |
| disp_size | input | 2 | Width code: 00 8-bit, 01 16-bit, 10 or 11 32-bit |
| taken | input | 1 | Branch condition outcome |
| next_pc | output | 32 | Registered next program counter |
| align_err | output | 1 | Registered misaligned-target flag |

## Verification
Two decisions can meet in a single cycle: the alignment check on a long displacement and the choice between the target and the fall-through address. The bench sends odd 16-bit and 32-bit displacements with `taken` both high and low. It expects the error and a held counter only when the branch is taken, and a clean `seq_pc` when it is not. Wrap-around targets and odd short fields complete the cases where the add and the error logic could interfere.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic [1:0] {
    DSZ_BYTE = 2'b00,
    DSZ_HALF = 2'b01,
    DSZ_WORD = 2'b10,
    DSZ_ALT  = 2'b11
  } dsz_e;

  localparam int unsigned SHORT_W = 8;
  localparam int unsigned HALF_W  = 16;
endpackage

// File: rtl/bt_disp_extend.sv
module bt_disp_extend
  import bt_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] raw,
  input  logic [1:0]   size,
  output logic [W-1:0] offs,
  output logic         long_form
);
  logic [W-1:0] ext_short;
  logic [W-1:0] ext_half;

  // short field is in halfword units: sign-extend then scale by two
  assign ext_short = {{(W-SHORT_W-1){raw[SHORT_W-1]}}, raw[SHORT_W-1:0], 1'b0};
  assign ext_half  = {{(W-HALF_W){raw[HALF_W-1]}}, raw[HALF_W-1:0]};

  always_comb begin
    long_form = 1'b1;
    case (dsz_e'(size))
      DSZ_BYTE: begin
        offs      = ext_short;
        long_form = 1'b0;
      end
      DSZ_HALF: offs = ext_half;
      default:  offs = raw;
    endcase
  end
endmodule

// File: rtl/bt_target_add.sv
module bt_target_add #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] base_pc,
  input  logic [W-1:0] seq_pc,
  input  logic [W-1:0] offs,
  input  logic         long_form,
  input  logic         taken,
  output logic [W-1:0] sel_pc,
  output logic         misalign,
  output logic         pc_load
);
  logic [W-1:0] target;

  assign target = base_pc + offs;

  always_comb begin
    misalign = taken & long_form & offs[0];
    pc_load  = ~misalign;
    sel_pc   = taken ? target : seq_pc;
  end
endmodule

// File: rtl/bt_target_calc.sv
module bt_target_calc #(
  parameter int unsigned  PC_W     = 32,
  parameter logic [31:0]  RESET_PC = 32'h0000_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [PC_W-1:0] br_pc,
  input  logic [PC_W-1:0] seq_pc,
  input  logic [PC_W-1:0] disp_raw,
  input  logic [1:0]      disp_size,
  input  logic            taken,
  output logic [PC_W-1:0] next_pc,
  output logic            align_err
);
  logic [PC_W-1:0] offs;
  logic            long_form;
  logic [PC_W-1:0] sel_pc;
  logic            misalign;
  logic            pc_load;

  logic [PC_W-1:0] pc_q, pc_d;
  logic            err_q, err_d;
  logic            pc_en, err_en;

  bt_disp_extend #(.W(PC_W)) u_ext (
    .raw       (disp_raw),
    .size      (disp_size),
    .offs      (offs),
    .long_form (long_form)
  );

  bt_target_add #(.W(PC_W)) u_add (
    .base_pc   (br_pc),
    .seq_pc    (seq_pc),
    .offs      (offs),
    .long_form (long_form),
    .taken     (taken),
    .sel_pc    (sel_pc),
    .misalign  (misalign),
    .pc_load   (pc_load)
  );

  // next-state
  always_comb begin
    pc_en  = in_valid & pc_load;
    err_en = in_valid;
    pc_d   = sel_pc;
    err_d  = misalign;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= RESET_PC[PC_W-1:0];
      err_q <= 1'b0;
    end else begin
      if (pc_en)  pc_q  <= pc_d;
      if (err_en) err_q <= err_d;
    end
  end

  assign next_pc   = pc_q;
  assign align_err = err_q;
endmodule

// File: rtl/bt_target_calc_chk.sv
module bt_target_calc_chk #(
  parameter int unsigned PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [PC_W-1:0] br_pc,
  input logic [PC_W-1:0] seq_pc,
  input logic [PC_W-1:0] disp_raw,
  input logic [1:0]      disp_size,
  input logic            taken,
  input logic [PC_W-1:0] next_pc,
  input logic            align_err
);
  assert_short_scaled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && taken && disp_size == 2'b00) |->
      next_pc == $past(br_pc) + {{(PC_W-9){$past(disp_raw[7])}}, $past(disp_raw[7:0]), 1'b0});

  assert_odd_long_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && taken && disp_size != 2'b00 && disp_raw[0]) |->
      (align_err && next_pc == $past(next_pc)));

  assert_not_taken_seq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && !taken) |-> (next_pc == $past(seq_pc) && !align_err));

  assert_short_no_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && disp_size == 2'b00) |-> !align_err);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> ($stable(next_pc) && $stable(align_err)));
endmodule

bind bt_target_calc bt_target_calc_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .br_pc(br_pc),
  .seq_pc(seq_pc), .disp_raw(disp_raw), .disp_size(disp_size),
  .taken(taken), .next_pc(next_pc), .align_err(align_err)
);

// File: tb/test_bt_target_calc.sv
`timescale 1ns/1ps
module test_bt_target_calc;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] br_pc, seq_pc, disp_raw;
  logic [1:0]  disp_size;
  logic        taken;
  logic [31:0] next_pc;
  logic        align_err;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [31:0] exp_pc;
  logic        exp_err;

  always #2 clk = ~clk;

  bt_target_calc i_bt_target_calc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .br_pc(br_pc),
    .seq_pc(seq_pc), .disp_raw(disp_raw), .disp_size(disp_size),
    .taken(taken), .next_pc(next_pc), .align_err(align_err)
  );

  function automatic logic [31:0] ref_offset(logic [31:0] d, logic [1:0] s);
    int v;
    if (s == 2'b00)      v = int'($signed(d[7:0])) * 2;
    else if (s == 2'b01) v = int'($signed(d[15:0]));
    else                 v = int'($signed(d));
    return 32'(v);
  endfunction

  function automatic string req_of(logic v, logic t, logic [1:0] s, logic [31:0] d);
    if (!v)                   return "R10";
    if (!t)                   return "R7";
    if (s == 2'b00)           return "R2/R8";
    if (d[0])                 return "R6";
    if (s == 2'b01)           return "R3";
    return "R4";
  endfunction

  task automatic compare(string req);
    vectors++;
    if (next_pc !== exp_pc || align_err !== exp_err) begin
      errors++;
      $display("FAIL %s: next_pc=%h align_err=%b expected next_pc=%h align_err=%b",
               req, next_pc, align_err, exp_pc, exp_err);
    end
  endtask

  task automatic apply(logic v, logic [31:0] pc, logic [31:0] sq, logic [31:0] d,
                       logic [1:0] s, logic t, string tag);
    string req;
    in_valid = v; br_pc = pc; seq_pc = sq; disp_raw = d; disp_size = s; taken = t;
    req = (tag != "") ? tag : req_of(v, t, s, d);
    if (v) begin
      if (!t) begin
        exp_pc = sq; exp_err = 1'b0;
      end else if (s != 2'b00 && d[0]) begin
        exp_err = 1'b1;
      end else begin
        exp_pc = pc + ref_offset(d, s); exp_err = 1'b0;
      end
    end
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; br_pc = '0; seq_pc = '0;
    disp_raw = '0; disp_size = '0; taken = 1'b0;
    exp_pc = 32'h0; exp_err = 1'b0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    // directed corners
    apply(1, 32'h0000_1000, 32'h0000_1002, 32'h0000_0010, 2'b00, 1, "R2");
    apply(1, 32'h0000_1000, 32'h0000_1002, 32'h0000_0080, 2'b00, 1, "R2");
    apply(1, 32'h0000_1000, 32'h0000_1002, 32'hFFFF_FF03, 2'b00, 1, "R8");
    apply(1, 32'h0000_1000, 32'h0000_1002, 32'hABCD_7F00, 2'b00, 1, "R9");
    apply(1, 32'h0004_0000, 32'h0004_0004, 32'h0000_8000, 2'b01, 1, "R3");
    apply(1, 32'h0004_0000, 32'h0004_0004, 32'h1234_0ABC, 2'b01, 1, "R9");
    apply(1, 32'h1000_0000, 32'h1000_0006, 32'hF000_0000, 2'b10, 1, "R4");
    apply(1, 32'h1000_0000, 32'h1000_0006, 32'h0000_0100, 2'b11, 1, "R4");
    apply(1, 32'hFFFF_FFF0, 32'hFFFF_FFF2, 32'h0000_0010, 2'b00, 1, "R5");
    apply(1, 32'h0000_0010, 32'h0000_0012, 32'hFFFF_FFE0, 2'b10, 1, "R5");
    apply(1, 32'h0000_2000, 32'h0000_2004, 32'h0000_0011, 2'b01, 1, "R6");
    apply(1, 32'h0000_2000, 32'h0000_2004, 32'h0000_0011, 2'b10, 1, "R6");
    apply(0, 32'h5555_5554, 32'h6666_6666, 32'h0000_0002, 2'b10, 1, "R10");
    apply(1, 32'h0000_2000, 32'h0000_2004, 32'h0000_0011, 2'b10, 0, "R7");
    apply(1, 32'h0000_3000, 32'h0000_3008, 32'h0000_0013, 2'b11, 0, "R7");
    apply(0, 32'h0, 32'h0, 32'h0, 2'b00, 0, "R10");

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] pc, d;
      logic [1:0]  s;
      logic        v, t;
      pc = $urandom() & 32'hFFFF_FFFE;
      d  = $urandom();
      s  = 2'($urandom_range(0, 3));
      v  = ($urandom_range(0, 9) != 0);
      t  = ($urandom_range(0, 3) != 0);
      if (s != 2'b00 && $urandom_range(0, 2) != 0) d[0] = 1'b0;
      apply(v, pc, pc + 32'd4, d, s, t, "");
    end

    in_valid = 1'b0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule